// File: doc/BRIEF.md
# Drive Condition Abort Supervisor

This block watches the condition lines of a disk drive while the controller core runs a command, and decides when that command has to be stopped. It synchronises the ready, write-protect, write-fault and track-zero inputs. It weighs each condition against the command type and the write phase that the core reports. When a condition applies, it issues a single-cycle abort request, and the core uses that request both to stop the command and to raise its completion interrupt. The block also holds sticky status bits for protect and fault aborts, live not-ready and track-zero status, and the zone output that marks the inner tracks during a transfer.

One drive pin does two jobs. While the write gate is high it is the write-fault input. While the write gate is low the block can pull it low as an open-drain output, so that a released pin means the data-separator oscillator is enabled. The block owns the output enable of that pin. It only reads the pin as a fault input after the write gate has been high for long enough to flush the synchroniser of stale values.

All interfaces are plain level or pulse signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `drive_abort_supervisor`

## Requirements
- R1: While `cmd_active` is high and `cmd_positioning` is low, a low `drv_ready` produces an abort with `abort_cause` = 3 (not ready).
- R2: While `cmd_positioning` is high, `drv_ready` never causes an abort.
- R3: While `cmd_active` and `write_pending` are high, a low `drv_wprot_n` produces an abort with `abort_cause` = 1. That abort sets `st_wprot`, which stays set until the next rising edge of `cmd_active`.
- R4: Once the write-fault window is open, a low `fault_pin_i` produces an abort with `abort_cause` = 2 and sets `st_wfault`, which is sticky in the same way as `st_wprot`. The window is open when `wgate` is high in the current cycle and in each of the previous SYNC_STAGES+1 cycles.
- R5: `fault_pin_oe` (1 = pull the pin low) equals `!wgate && !vfo_enable`. While the window is closed, including the first cycles after `wgate` rises, the pin level never causes an abort.
- R6: `trk43` is registered one clock after its inputs. It is high only when `disk_xfer` is high and `track_num` >= 44.
- R7: `st_not_ready` is the inverse of the synchronised `drv_ready`, and `st_track0` is the inverse of the synchronised `drv_trk0_n`. Each follows its input after SYNC_STAGES clocks.
- R8: `abort_pulse` is high for exactly one clock, and rises at most once per high interval of `cmd_active`. `abort_cause` is 0 whenever `abort_pulse` is low.
- R9: When more than one condition holds in the same cycle, the cause reported is write protect first, then write fault, then not ready.
- R10: A drive input change reaches `abort_pulse` on the (SYNC_STAGES+1)-th rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_active | input | 1 | Core is executing a command |
| cmd_positioning | input | 1 | Current command is a head-positioning command |
| write_pending | input | 1 | Core is about to start a disk write |
| wgate | input | 1 | Write gate from the core |
| vfo_enable | input | 1 | Core requests the separator oscillator enabled (pin released) |
| disk_xfer | input | 1 | Disk read or write transfer in progress |
| track_num | input | 8 | Current head track number |
| drv_ready | input | 1 | Drive ready, active high |
| drv_wprot_n | input | 1 | Write protect, active low |
| drv_trk0_n | input | 1 | Head at track zero, active low |
| fault_pin_i | input | 1 | Level seen on the shared fault / oscillator-enable pin |
| fault_pin_oe | output | 1 | Pull the shared pin low |
| abort_pulse | output | 1 | One-cycle abort request; also raises the completion interrupt |
| abort_cause | output | 2 | 0 none, 1 write protect, 2 write fault, 3 not ready |
| st_not_ready | output | 1 | Not-ready status |
| st_wprot | output | 1 | Sticky write-protect abort status |
| st_wfault | output | 1 | Sticky write-fault abort status |
| st_track0 | output | 1 | Head-at-track-zero status |
| trk43 | output | 1 | Inner-zone indicator during transfers |

## Verification
The assertions assume that the core inputs `cmd_active`, `cmd_positioning`, `write_pending` and `wgate` are synchronous to `clk`, and that the core drops `cmd_active` between commands so that a new command can be seen. The bench changes these inputs only just after a rising edge. It loads each drive condition while no command is active, and waits longer than the synchroniser and fault-window delays before it raises `cmd_active`. It models the shared pin as pulled low whenever `fault_pin_oe` is high. This keeps the pin stale low at the moment the write gate rises, which tests the window directly.

// File: rtl/das_pkg.sv
package das_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_WPROT  = 2'd1,
    CAUSE_WFAULT = 2'd2,
    CAUSE_NREADY = 2'd3
  } abort_cause_e;

  localparam int unsigned DRV_IN_W    = 4;
  localparam int unsigned IDX_READY   = 0;
  localparam int unsigned IDX_WPROT_N = 1;
  localparam int unsigned IDX_FAULT_N = 2;
  localparam int unsigned IDX_TRK0_N  = 3;
endpackage

// File: rtl/das_sync.sv
module das_sync #(
  parameter int unsigned W           = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [W-1:0] RST_VAL    = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [SYNC_STAGES-1:0][W-1:0] stg;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[SYNC_STAGES-1];
endmodule

// File: rtl/das_track_zone.sv
module das_track_zone #(
  parameter int unsigned TRK_W      = 8,
  parameter int unsigned ZONE_FIRST = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer,
  input  logic [TRK_W-1:0] track,
  output logic             zone
);
  localparam logic [TRK_W-1:0] FIRST = TRK_W'(ZONE_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zone <= 1'b0;
    else        zone <= xfer && (track >= FIRST);
  end

  AST_ZONE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(xfer) |-> !zone); // R6
  AST_ZONE_OUTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(track) < FIRST) |-> !zone); // R6
endmodule

// File: rtl/das_abort_arbiter.sv
module das_abort_arbiter
  import das_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_active,
  input  logic         cmd_positioning,
  input  logic         write_pending,
  input  logic         wgate,
  input  logic         ready_s,
  input  logic         wprot_n_s,
  input  logic         fault_n_s,
  output logic         abort_pulse,
  output abort_cause_e abort_cause,
  output logic         st_wprot,
  output logic         st_wfault
);
  localparam int unsigned WIN_W = SYNC_STAGES + 1;

  logic [WIN_W-1:0] wg_hist;
  logic             wf_window;
  logic             cond_wp, cond_wf, cond_nr;
  abort_cause_e     sel;
  logic             armed, fire, cmd_prev, cmd_start;
  logic [1:0]       n_abort;

  // write-gate history: fault pin is trusted only after stale samples flush
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wg_hist <= '0;
    else        wg_hist <= {wg_hist[WIN_W-2:0], wgate};
  end
  assign wf_window = wgate && (&wg_hist);

  assign cond_wp = cmd_active && write_pending && !wprot_n_s;
  assign cond_wf = cmd_active && wf_window && !fault_n_s;
  assign cond_nr = cmd_active && !cmd_positioning && !ready_s;

  always_comb begin
    if (cond_wp)      sel = CAUSE_WPROT;
    else if (cond_wf) sel = CAUSE_WFAULT;
    else if (cond_nr) sel = CAUSE_NREADY;
    else              sel = CAUSE_NONE;
  end

  assign fire      = armed && (sel != CAUSE_NONE);
  assign cmd_start = cmd_active && !cmd_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b1;
      cmd_prev    <= 1'b0;
      abort_pulse <= 1'b0;
      abort_cause <= CAUSE_NONE;
    end else begin
      cmd_prev    <= cmd_active;
      abort_pulse <= fire;
      abort_cause <= fire ? sel : CAUSE_NONE;
      if (!cmd_active) armed <= 1'b1;
      else if (fire)   armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_wprot  <= 1'b0;
      st_wfault <= 1'b0;
    end else begin
      if (fire && sel == CAUSE_WPROT) st_wprot <= 1'b1;
      else if (cmd_start)             st_wprot <= 1'b0;
      if (fire && sel == CAUSE_WFAULT) st_wfault <= 1'b1;
      else if (cmd_start)              st_wfault <= 1'b0;
    end
  end

  // abort counter per command, observed by the checks only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            n_abort <= '0;
    else if (cmd_start)                    n_abort <= {1'b0, abort_pulse};
    else if (abort_pulse && n_abort != 2'd3) n_abort <= n_abort + 2'd1;
  end

  AST_NR_NEEDS_LOW_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_cause == CAUSE_NREADY) |-> !$past(ready_s)); // R1
  AST_NR_NOT_POSITIONING: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_cause == CAUSE_NREADY) |-> !$past(cmd_positioning)); // R2
  AST_WP_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_cause == CAUSE_WPROT) |-> st_wprot); // R3
  AST_WF_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_cause == CAUSE_WFAULT) |-> st_wfault); // R4
  AST_WF_GATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_cause == CAUSE_WFAULT) |-> ($past(wgate) && $past(wgate, 2))); // R5
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse); // R8
  AST_ONE_PER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    n_abort <= 2'd1); // R8
  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_pulse |-> (abort_cause == CAUSE_NONE)); // R8
  AST_PRIO_WP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_cause != CAUSE_WPROT) |-> !$past(cond_wp)); // R9
  AST_PRIO_NR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_cause == CAUSE_NREADY) |-> !$past(cond_wf)); // R9
endmodule

// File: rtl/drive_abort_supervisor.sv
module drive_abort_supervisor
  import das_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TRK_W       = 8,
  parameter int unsigned ZONE_FIRST  = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_active,
  input  logic             cmd_positioning,
  input  logic             write_pending,
  input  logic             wgate,
  input  logic             vfo_enable,
  input  logic             disk_xfer,
  input  logic [TRK_W-1:0] track_num,
  input  logic             drv_ready,
  input  logic             drv_wprot_n,
  input  logic             drv_trk0_n,
  input  logic             fault_pin_i,
  output logic             fault_pin_oe,
  output logic             abort_pulse,
  output logic [1:0]       abort_cause,
  output logic             st_not_ready,
  output logic             st_wprot,
  output logic             st_wfault,
  output logic             st_track0,
  output logic             trk43
);
  logic [DRV_IN_W-1:0] raw_in, syn_in;
  abort_cause_e        cause_e;

  always_comb begin
    raw_in              = '0;
    raw_in[IDX_READY]   = drv_ready;
    raw_in[IDX_WPROT_N] = drv_wprot_n;
    raw_in[IDX_FAULT_N] = fault_pin_i;
    raw_in[IDX_TRK0_N]  = drv_trk0_n;
  end

  das_sync #(
    .W(DRV_IN_W), .SYNC_STAGES(SYNC_STAGES), .RST_VAL('1)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  // open-drain: pin is an input while writing, else pulled low when oscillator off
  assign fault_pin_oe = !wgate && !vfo_enable;

  das_abort_arbiter #(.SYNC_STAGES(SYNC_STAGES)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .cmd_active(cmd_active), .cmd_positioning(cmd_positioning),
    .write_pending(write_pending), .wgate(wgate),
    .ready_s(syn_in[IDX_READY]), .wprot_n_s(syn_in[IDX_WPROT_N]),
    .fault_n_s(syn_in[IDX_FAULT_N]),
    .abort_pulse(abort_pulse), .abort_cause(cause_e),
    .st_wprot(st_wprot), .st_wfault(st_wfault)
  );
  assign abort_cause = 2'(cause_e);

  das_track_zone #(.TRK_W(TRK_W), .ZONE_FIRST(ZONE_FIRST)) u_zone (
    .clk(clk), .rst_n(rst_n), .xfer(disk_xfer), .track(track_num), .zone(trk43)
  );

  assign st_not_ready = !syn_in[IDX_READY];
  assign st_track0    = !syn_in[IDX_TRK0_N];

  AST_PIN_NOT_DRIVEN_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_cause == 2'd2) |-> !$past(fault_pin_oe)); // R5
endmodule

// File: tb/drive_abort_supervisor_test.sv
module drive_abort_supervisor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_active = 0, cmd_positioning = 0, write_pending = 0, wgate = 0;
  logic vfo_enable = 1, disk_xfer = 0;
  logic [7:0] track_num = 8'd0;
  logic drv_ready = 1, drv_wprot_n = 1, drv_trk0_n = 1, flt_drv = 1;
  logic fault_pin_i, fault_pin_oe, abort_pulse, st_not_ready, st_wprot, st_wfault, st_track0, trk43;
  logic [1:0] abort_cause;

  int n_chk = 0, n_bad = 0, hi_cycles = 0, last_cause = 0;

  always #2.5 clk = ~clk;

  assign fault_pin_i = fault_pin_oe ? 1'b0 : flt_drv;

  drive_abort_supervisor uut (
    .clk(clk), .rst_n(rst_n), .cmd_active(cmd_active), .cmd_positioning(cmd_positioning),
    .write_pending(write_pending), .wgate(wgate), .vfo_enable(vfo_enable),
    .disk_xfer(disk_xfer), .track_num(track_num), .drv_ready(drv_ready),
    .drv_wprot_n(drv_wprot_n), .drv_trk0_n(drv_trk0_n), .fault_pin_i(fault_pin_i),
    .fault_pin_oe(fault_pin_oe), .abort_pulse(abort_pulse), .abort_cause(abort_cause),
    .st_not_ready(st_not_ready), .st_wprot(st_wprot), .st_wfault(st_wfault),
    .st_track0(st_track0), .trk43(trk43)
  );

  always @(negedge clk) if (abort_pulse) begin
    hi_cycles++;
    last_cause = int'(abort_cause);
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic benign();
    cmd_positioning = 0; write_pending = 0; wgate = 0;
    drv_ready = 1; drv_wprot_n = 1; flt_drv = 1; vfo_enable = 1;
  endtask

  // {pos,wpend,wg,rdy,wpn,flt, cnt[2], cause[2], st_wp, st_wf}
  localparam logic [11:0] VEC [0:9] = '{
    12'b0_0_0_1_1_1_00_00_0_0, // quiet command
    12'b0_0_0_0_1_1_01_11_0_0, // R1 not ready
    12'b1_0_0_0_1_1_00_00_0_0, // R2 positioning ignores ready
    12'b0_1_0_1_0_1_01_01_1_0, // R3 protect before write
    12'b0_0_0_1_0_1_00_00_0_0, // R3 protect without pending write
    12'b0_0_1_1_1_0_01_10_0_1, // R4 write fault
    12'b0_0_0_1_1_0_00_00_0_0, // R5 pin low with gate off
    12'b0_1_1_0_0_0_01_01_1_0, // R9 all three
    12'b0_0_1_0_1_0_01_10_0_1, // R9 fault over not ready
    12'b1_0_1_0_1_0_01_10_0_1  // R4 fault in positioning
  };

  initial begin : watchdog
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(4);
    chk("R8 reset pulse", int'(abort_pulse), 0);
    chk("R8 reset cause", int'(abort_cause), 0);
    chk("R3 reset st_wprot", int'(st_wprot), 0);
    chk("R4 reset st_wfault", int'(st_wfault), 0);
    chk("R6 reset trk43", int'(trk43), 0);
    chk("R7 reset st_not_ready", int'(st_not_ready), 0);

    foreach (VEC[k]) begin
      logic [11:0] v;
      v = VEC[k];
      cmd_positioning = v[11]; write_pending = v[10]; wgate = v[9];
      drv_ready = v[8]; drv_wprot_n = v[7]; flt_drv = v[6];
      tick(6);
      hi_cycles = 0; last_cause = 0;
      cmd_active = 1;
      tick(8);
      chk($sformatf("R8 vec%0d pulse cycles", k), hi_cycles, int'(v[5:4]));
      chk($sformatf("R9 vec%0d cause", k), last_cause, int'(v[3:2]));
      chk($sformatf("R3 vec%0d st_wprot", k), int'(st_wprot), int'(v[1]));
      chk($sformatf("R4 vec%0d st_wfault", k), int'(st_wfault), int'(v[0]));
      benign();
      cmd_active = 0;
      tick(6);
    end

    // R10 latency: ready drop mid-command shows on 3rd edge
    cmd_active = 1; hi_cycles = 0;
    tick(4);
    drv_ready = 0;
    tick(2);
    chk("R10 no pulse before 3rd edge", int'(abort_pulse), 0);
    tick(1);
    chk("R10 pulse on 3rd edge", int'(abort_pulse), 1);
    tick(1);
    chk("R8 pulse one clock", int'(abort_pulse), 0);
    drv_ready = 1; tick(4); drv_ready = 0; tick(6);
    chk("R8 one abort per command", hi_cycles, 1);
    benign(); cmd_active = 0; tick(6);

    // R5 stale low pin when gate rises must not abort
    cmd_positioning = 1; vfo_enable = 0; cmd_active = 1;
    tick(1);
    chk("R5 oe when gate off and vfo off", int'(fault_pin_oe), 1);
    tick(5);
    hi_cycles = 0;
    wgate = 1; flt_drv = 1;
    tick(1);
    chk("R5 pin released in write", int'(fault_pin_oe), 0);
    tick(8);
    chk("R5 stale pin ignored", hi_cycles, 0);
    flt_drv = 0;
    tick(5);
    chk("R4 fault after window", hi_cycles, 1);
    chk("R4 cause fault", last_cause, 2);
    benign(); cmd_active = 0; tick(2);
    chk("R5 oe released with vfo on", int'(fault_pin_oe), 0);
    tick(4);

    // R7 status
    drv_ready = 0; drv_trk0_n = 0;
    tick(3);
    chk("R7 st_not_ready", int'(st_not_ready), 1);
    chk("R7 st_track0", int'(st_track0), 1);
    drv_ready = 1; drv_trk0_n = 1;
    tick(3);
    chk("R7 st_track0 clear", int'(st_track0), 0);

    // R6 zone
    disk_xfer = 1; track_num = 8'd43; tick(2);
    chk("R6 track 43", int'(trk43), 0);
    track_num = 8'd44; tick(1);
    chk("R6 track 44", int'(trk43), 1);
    track_num = 8'd76; tick(1);
    chk("R6 track 76", int'(trk43), 1);
    disk_xfer = 0; tick(1);
    chk("R6 no transfer", int'(trk43), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule